// File: doc/BRIEF.md
# Self-Loop Clock-Gated Moore State Machine

This block is a four-state Moore machine. Its state register is clocked only in cycles where the state can change. A small activation decoder looks at the present state and the two-bit primary input. It runs beside the next-state logic, not after it. It flags every (state, input) pair for which the machine's graph has a self-loop. In those cycles the register's clock edge is removed, so the flip-flops do not switch. Because the outputs are decoded from the state alone, holding the state also holds the outputs.

The enable goes through a level-sensitive latch that is open while the clock is low. The latched value is then ANDed with the clock to make the register clock. A change on the enable during the high phase therefore cannot cut or stretch a pulse. The latched enable and the gated clock both appear on ports, so surrounding logic and the bench can see which edges were suppressed.

Reset is synchronous and active high. While reset is asserted the enable is forced on, so the reset edge always reaches the register, even in a self-loop cycle.

Top module: `selfloop_gated_fsm`

## Requirements
- R1: With `rst` high at a rising `clk` edge, the state becomes IDLE and `z_o` becomes 3'b000. This holds even when the present (state, input) pair is a self-loop.
- R2: Out of reset, the enable seen on `clk_en_o` during the high phase is 0 exactly for these self-loop pairs, and 1 otherwise:
  - IDLE with `x_i` 00 or 11
  - ARM with `x_i` 01 or 10
  - RUN with `x_i` 01, 10 or 11
- R3: In a cycle whose enable is 0, `gclk_o` has no rising edge and `state_o` and `z_o` keep their values.
- R4: Transitions taken on an enabled edge:
  - IDLE goes to ARM on 01 and to RUN on 10.
  - ARM goes to RUN on 11 and back to IDLE on 00.
  - RUN goes to DONE on 00.
- R5: Moore outputs: `z_o` is 3'b000 in IDLE, 3'b001 in ARM, 3'b110 in RUN and 3'b100 in DONE.
- R6: DONE has no self-loop. It returns to IDLE on the next edge for every input value.
- R7: `gclk_o` is low whenever `clk` is low. During the high phase, `gclk_o` equals the enable latched while `clk` was low.
- R8: `state_o` encodes IDLE as 0, ARM as 1, RUN as 2 and DONE as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 2 | Primary input vector |
| z_o | output | 3 | Moore output, a function of the state only |
| state_o | output | 2 | Present state code |
| clk_en_o | output | 1 | Latched clock-activation enable |
| gclk_o | output | 1 | Gated register clock, for observation |

## Verification
A directed walk visits every state. In each state it applies every input value that holds and every value that leaves. This separates a gating decoder that suppresses a real transition from one that lets a self-loop edge through. Reset is applied while the machine sits in a self-loop (RUN with input 11), which shows whether reset overrides the gate. A long pseudo-random input stream is then compared, cycle by cycle, against an ungated reference model. The number of gated-clock edges is totalled against the number of non-self-loop cycles. A spare or missing edge shows up in that total, even if the state happens to agree.

// File: rtl/sgfsm_pkg.sv
package sgfsm_pkg;

    localparam int IN_W  = 2;
    localparam int OUT_W = 3;
    localparam int ST_W  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } fsm_state_t;

    // Transition function of the graph.
    function automatic fsm_state_t next_state(input fsm_state_t s, input logic [IN_W-1:0] x);
        fsm_state_t n;
        n = s;
        unique case (s)
            ST_IDLE: begin
                if (x == 2'b01)      n = ST_ARM;
                else if (x == 2'b10) n = ST_RUN;
            end
            ST_ARM: begin
                if (x == 2'b11)      n = ST_RUN;
                else if (x == 2'b00) n = ST_IDLE;
            end
            ST_RUN: begin
                if (x == 2'b00)      n = ST_DONE;
            end
            ST_DONE: n = ST_IDLE;
            default: n = ST_IDLE;
        endcase
        return n;
    endfunction

    // Activation decode: written directly from the graph's self-loop arcs,
    // not derived from next_state, so the two can be cross-checked.
    function automatic logic is_self_loop(input fsm_state_t s, input logic [IN_W-1:0] x);
        logic hold;
        unique case (s)
            ST_IDLE: hold = (x == 2'b00) || (x == 2'b11);
            ST_ARM:  hold = (x == 2'b01) || (x == 2'b10);
            ST_RUN:  hold = (x != 2'b00);
            default: hold = 1'b0;
        endcase
        return hold;
    endfunction

    function automatic logic [OUT_W-1:0] moore_out(input fsm_state_t s);
        logic [OUT_W-1:0] z;
        unique case (s)
            ST_IDLE: z = 3'b000;
            ST_ARM:  z = 3'b001;
            ST_RUN:  z = 3'b110;
            ST_DONE: z = 3'b100;
            default: z = 3'b000;
        endcase
        return z;
    endfunction

endpackage

// File: rtl/sgfsm_activation.sv
module sgfsm_activation
    import sgfsm_pkg::*;
(
    input  logic            rst,
    input  fsm_state_t      state,
    input  logic [IN_W-1:0] x,
    output logic            en
);
    // Reset must always reach the register, so it forces the enable on.
    always_comb begin
        en = rst || !is_self_loop(state, x);
    end
endmodule

// File: rtl/sgfsm_clock_gate.sv
module sgfsm_clock_gate (
    input  logic clk,
    input  logic en,
    output logic en_lat,
    output logic gclk
);
    // Latch is open in the low phase and closed in the high phase.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/sgfsm_state_reg.sv
module sgfsm_state_reg
    import sgfsm_pkg::*;
(
    input  logic             gclk,
    input  logic             rst,
    input  logic [IN_W-1:0]  x,
    output fsm_state_t       state,
    output fsm_state_t       nxt,
    output logic [OUT_W-1:0] z
);
    always_comb begin
        nxt = next_state(state, x);
        z   = moore_out(state);
    end

    always_ff @(posedge gclk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/selfloop_gated_fsm.sv
module selfloop_gated_fsm
    import sgfsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] z_o,
    output logic [ST_W-1:0]  state_o,
    output logic             clk_en_o,
    output logic             gclk_o
);
    fsm_state_t state_q;
    fsm_state_t nxt;
    logic       en_raw;
    logic       en_lat;
    logic       gclk;

    sgfsm_activation u_act (
        .rst   (rst),
        .state (state_q),
        .x     (x_i),
        .en    (en_raw)
    );

    sgfsm_clock_gate u_cg (
        .clk    (clk),
        .en     (en_raw),
        .en_lat (en_lat),
        .gclk   (gclk)
    );

    sgfsm_state_reg u_reg (
        .gclk  (gclk),
        .rst   (rst),
        .x     (x_i),
        .state (state_q),
        .nxt   (nxt),
        .z     (z_o)
    );

    assign state_o  = state_q;
    assign clk_en_o = en_lat;
    assign gclk_o   = gclk;

    // R2: an edge is removed only when the next-state logic would not move.
    a_r2_gate_only_on_selfloop: assert property (@(posedge clk) disable iff (rst)
        !en_raw |-> (nxt == state_q));

    // R3: a gated edge leaves the state untouched.
    a_r3_gated_holds_state: assert property (@(posedge clk) disable iff (rst)
        !clk_en_o |=> $stable(state_q));

    // R5: Moore outputs cannot move while the state is held.
    a_r5_out_follows_state: assert property (@(posedge clk) disable iff (rst)
        $stable(state_q) |-> $stable(z_o));

    // R1: reset lands in IDLE even when the graph would self-loop.
    a_r1_reset_to_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE));

    // R6: DONE never holds.
    a_r6_done_exits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: tb/selfloop_gated_fsm_test.sv
module selfloop_gated_fsm_test;

    typedef struct {
        logic [1:0] st;
        logic [2:0] z;
        logic       en;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] x   = 2'b00;
    logic [2:0] z_o;
    logic [1:0] state_o;
    logic       clk_en_o;
    logic       gclk_o;

    int checks = 0;
    int failures = 0;
    int gclk_edges = 0;
    int exp_edges = 0;
    int suppressed = 0;
    logic [1:0] ref_st = 2'd0;
    exp_t q[$];
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    selfloop_gated_fsm uut (
        .clk(clk), .rst(rst), .x_i(x), .z_o(z_o),
        .state_o(state_o), .clk_en_o(clk_en_o), .gclk_o(gclk_o)
    );

    always @(posedge gclk_o) gclk_edges++;

    // Reference model written from the requirements (R4, R6, R8 codes).
    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic [1:0] xi);
        case (s)
            2'd0: return (xi == 2'b01) ? 2'd1 : (xi == 2'b10) ? 2'd2 : 2'd0;
            2'd1: return (xi == 2'b11) ? 2'd2 : (xi == 2'b00) ? 2'd0 : 2'd1;
            2'd2: return (xi == 2'b00) ? 2'd3 : 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] ref_z(input logic [1:0] s);
        case (s)
            2'd0: return 3'b000;
            2'd1: return 3'b001;
            2'd2: return 3'b110;
            default: return 3'b100;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues what must follow.
    task automatic step(input logic r, input logic [1:0] xi);
        exp_t e;
        logic [1:0] n;
        @(negedge clk);
        rst = r;
        x   = xi;
        n = r ? 2'd0 : ref_next(ref_st, xi);
        e.en = r || (n != ref_st) || (ref_st == 2'd3);
        if (r)                    e.tag = "R1";
        else if (ref_st == 2'd3)  e.tag = "R6";
        else if (!e.en)           e.tag = "R3";
        else                      e.tag = "R4";
        if (e.en) exp_edges++; else suppressed++;
        e.st = n;
        e.z  = ref_z(n);
        ref_st = n;
        q.push_back(e);
    endtask

    // Monitor: mid-high phase checks of enable and gated clock, then the result.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                check("R2 enable", {7'd0, clk_en_o}, {7'd0, e.en});
                check("R7 gclk high phase", {7'd0, gclk_o}, {7'd0, e.en});
                check({e.tag, " state (R8 code)"}, {6'd0, state_o}, {6'd0, e.st});
                check({e.tag, " R5 output"}, {5'd0, z_o}, {5'd0, e.z});
                @(negedge clk);
                #5;
                check("R7 gclk low phase", {7'd0, gclk_o}, 8'd0);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        int start_edges;
        // R1 reset with a self-loop input present
        step(1, 2'b00);
        step(1, 2'b11);
        // IDLE holds (R3), then leaves (R4)
        step(0, 2'b00);
        step(0, 2'b11);
        step(0, 2'b01);   // -> ARM
        step(0, 2'b01);
        step(0, 2'b10);   // ARM holds
        step(0, 2'b11);   // -> RUN
        step(0, 2'b11);
        step(0, 2'b01);
        step(0, 2'b10);   // RUN holds
        step(0, 2'b00);   // -> DONE
        step(0, 2'b11);   // R6 DONE -> IDLE with any input
        step(0, 2'b10);   // -> RUN
        step(0, 2'b00);   // -> DONE
        step(0, 2'b00);   // -> IDLE
        step(0, 2'b01);   // -> ARM
        step(0, 2'b00);   // -> IDLE
        step(0, 2'b10);   // -> RUN
        step(0, 2'b11);
        step(1, 2'b11);   // R1 reset while RUN would self-loop
        step(0, 2'b01);
        step(0, 2'b11);   // -> RUN
        step(0, 2'b00);   // -> DONE
        step(0, 2'b01);   // R6 -> IDLE
        // pseudo-random sweep against the reference
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step((lfsr[7:2] == 6'd0), lfsr[1:0]);
        end
        step(0, 2'b00);
        @(negedge clk);
        @(negedge clk);
        // R3: total gated edges equals enabled cycles, so every suppressed
        // edge lined up with a self-loop cycle. Edges from the very first
        // reset cycle before the driver started are excluded.
        start_edges = 1;
        check("R3 gated edge total", 8'(gclk_edges - start_edges), 8'(exp_edges));
        check("R3 some edges suppressed", {7'd0, (suppressed > 0)}, 8'd1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule